// File: doc/BRIEF.md
# Accumulator Store Saturation Unit

This unit sits on the store path of a DSP datapath. It takes a 40-bit signed accumulator and produces the 16-bit 1.15 word that goes to data memory or to a working register. The accumulator has three fields. Bits 39:32 are guard bits, bits 31:16 are the high word and bits 15:0 are the low word. The same path serves three operations: a plain store, a store with rounding, and the write-back of an accumulator alongside a multiply-accumulate.

A store may first be rounded. Rounding is either half-up or half-to-even. The unit then optionally tests the rounded value against the 1.15 range. With saturation enabled, the guard bits and the high word together form a 24-bit signed value. A value outside 0xFF8000..0x007FFF is clamped to the largest positive or most negative 1.15 word, and bit 39 alone decides which. With saturation disabled, the high word leaves unchanged and the guard bits play no part.

The result is registered. It appears one cycle after the request, with a valid strobe and a per-store flag that marks a clamp. A sticky flag records that a clamp has happened since it was last cleared.

Top module: `acc_store_sat`

## Requirements
- R1: During and after reset, before any store, `out_valid`, `out_word`, `out_sat` and `sat_sticky` are all 0.
- R2: With `sat_en` = 0, `out_word` equals bits 31:16 of the (possibly rounded) accumulator, the guard bits have no effect, and `out_sat` is 0.
- R3: With `rnd_req` = 1 and `rnd_even` = 0, 0x8000 is added to the 40-bit accumulator, wrapping modulo 2^40, before the upper bits are taken. With `rnd_req` = 0 the low word is discarded (truncation).
- R4: With `rnd_req` = 1 and `rnd_even` = 1, an exact tie is rounded half-to-even. A tie means the low word equals 0x8000. On a tie the high part is incremented only when bit 16 is 1. Every other low word rounds as in R3. With `rnd_req` = 0, `rnd_even` has no effect.
- R5: With `sat_en` = 1, bit 39 = 0 and bits 39:16 above 0x007FFF, `out_word` is 0x7FFF and `out_sat` is 1.
- R6: With `sat_en` = 1, bit 39 = 1 and bits 39:16 below 0xFF8000 (as a signed 24-bit value), `out_word` is 0x8000 and `out_sat` is 1.
- R7: With `sat_en` = 1 and bits 39:16 within 0xFF8000..0x007FFF inclusive, `out_word` equals bits 31:16 and `out_sat` is 0.
- R8: The range test and the sign bit are both taken after rounding. A rounding carry that wraps the accumulator into negative values clamps to 0x8000.
- R9: A store accepted with `in_valid` = 1 shows its result on `out_word` and `out_sat` with `out_valid` = 1 one clock later. With no store, `out_valid` is 0 and `out_word` holds.
- R10: `sat_sticky` is set by any accepted store that clamps and stays set until `sticky_clr`. A clamp in the same cycle as `sticky_clr` leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Store request this cycle |
| acc_in | input | 40 | Accumulator to store |
| rnd_req | input | 1 | Round before store (1) or truncate (0) |
| rnd_even | input | 1 | Tie rule: 0 half-up, 1 half-to-even |
| sat_en | input | 1 | Data-write saturation enable |
| sticky_clr | input | 1 | Clear the sticky clamp flag |
| out_valid | output | 1 | Result valid strobe |
| out_word | output | 16 | Stored 1.15 word |
| out_sat | output | 1 | Result was clamped |
| sat_sticky | output | 1 | A clamp occurred since last clear |

## Verification
The hardest cases to reach from the ports both turn on the rounding carry. In one, the carry flips the sign bit of a nearly full positive accumulator. In the other, the half-to-even rule must detect an exact tie and skip the carry. Random accumulators almost never land there. The stimulus therefore sets the exact bit patterns by hand: 0x7FFFFF8000 rounded, 0x007FFF8000 with and without saturation, and tie words with bit 16 both clear and set. The same-cycle clash of `sticky_clr` with a clamping store is also driven on purpose.

// File: rtl/accsat_pkg.sv
package accsat_pkg;
  localparam int unsigned ACC_W_DEF   = 40;
  localparam int unsigned WORD_W_DEF  = 16;
  localparam int unsigned SYNC_STAGES = 2;

  typedef enum logic {
    RND_HALF_UP   = 1'b0,
    RND_HALF_EVEN = 1'b1
  } rnd_mode_e;
endpackage

// File: rtl/accsat_rst_sync.sv
module accsat_rst_sync #(
  parameter int unsigned STAGES = accsat_pkg::SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/accsat_round.sv
module accsat_round #(
  parameter int unsigned ACC_W   = accsat_pkg::ACC_W_DEF,
  parameter int unsigned WORD_W  = accsat_pkg::WORD_W_DEF,
  parameter bit          EVEN_EN = 1'b1,
  localparam int unsigned HI_W   = ACC_W - WORD_W
) (
  input  logic [ACC_W-1:0] acc,
  input  logic             rnd_req,
  input  accsat_pkg::rnd_mode_e mode,
  output logic [HI_W-1:0]  hi_rounded
);
  // Adding half an LSB of the kept part carries into it exactly when the
  // top dropped bit is set, so only the carry is formed here.
  logic carry;

  generate
    if (EVEN_EN) begin : g_even
      logic tie;
      always_comb begin
        tie   = acc[WORD_W-1] && (acc[WORD_W-2:0] == '0);
        carry = rnd_req && acc[WORD_W-1] &&
                !((mode == accsat_pkg::RND_HALF_EVEN) && tie && !acc[WORD_W]);
      end
    end else begin : g_up
      always_comb begin
        carry = rnd_req && acc[WORD_W-1];
      end
    end
  endgenerate

  always_comb begin
    hi_rounded = acc[ACC_W-1:WORD_W] + {{(HI_W-1){1'b0}}, carry};
  end
endmodule

// File: rtl/accsat_clamp.sv
module accsat_clamp #(
  parameter int unsigned ACC_W  = accsat_pkg::ACC_W_DEF,
  parameter int unsigned WORD_W = accsat_pkg::WORD_W_DEF,
  localparam int unsigned HI_W   = ACC_W - WORD_W,
  localparam int unsigned TEST_W = HI_W - WORD_W + 1
) (
  input  logic [HI_W-1:0]   hi,
  input  logic              sat_en,
  output logic [WORD_W-1:0] word,
  output logic              clamped
);
  localparam logic [WORD_W-1:0] MAX_POS = {1'b0, {(WORD_W-1){1'b1}}};
  localparam logic [WORD_W-1:0] MAX_NEG = {1'b1, {(WORD_W-1){1'b0}}};

  logic              sign;
  logic [TEST_W-1:0] top_bits;
  logic              out_of_range;

  always_comb begin
    sign         = hi[HI_W-1];
    top_bits     = hi[HI_W-1:WORD_W-1];
    out_of_range = (top_bits != {TEST_W{sign}});
    clamped      = sat_en && out_of_range;
    if (clamped) word = sign ? MAX_NEG : MAX_POS;
    else         word = hi[WORD_W-1:0];
  end
endmodule

// File: rtl/acc_store_sat.sv
module acc_store_sat #(
  parameter int unsigned ACC_W   = accsat_pkg::ACC_W_DEF,
  parameter int unsigned WORD_W  = accsat_pkg::WORD_W_DEF,
  parameter bit          EVEN_EN = 1'b1,
  localparam int unsigned HI_W   = ACC_W - WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [ACC_W-1:0]  acc_in,
  input  logic              rnd_req,
  input  logic              rnd_even,
  input  logic              sat_en,
  input  logic              sticky_clr,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word,
  output logic              out_sat,
  output logic              sat_sticky
);
  localparam logic [WORD_W-1:0] MAX_POS = {1'b0, {(WORD_W-1){1'b1}}};
  localparam logic [WORD_W-1:0] MAX_NEG = {1'b1, {(WORD_W-1){1'b0}}};

  logic                  rst_n_s;
  logic [HI_W-1:0]       hi_rnd;
  logic [WORD_W-1:0]     word_c;
  logic                  sat_c;
  accsat_pkg::rnd_mode_e mode_c;

  logic              valid_d, valid_q;
  logic [WORD_W-1:0] word_d,  word_q;
  logic              sat_d,   sat_q;
  logic              sticky_d, sticky_q;

  accsat_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  assign mode_c = rnd_even ? accsat_pkg::RND_HALF_EVEN : accsat_pkg::RND_HALF_UP;

  accsat_round #(.ACC_W(ACC_W), .WORD_W(WORD_W), .EVEN_EN(EVEN_EN)) u_round (
    .acc        (acc_in),
    .rnd_req    (rnd_req),
    .mode       (mode_c),
    .hi_rounded (hi_rnd)
  );

  accsat_clamp #(.ACC_W(ACC_W), .WORD_W(WORD_W)) u_clamp (
    .hi      (hi_rnd),
    .sat_en  (sat_en),
    .word    (word_c),
    .clamped (sat_c)
  );

  // next-state
  always_comb begin
    valid_d  = in_valid;
    word_d   = word_q;
    sat_d    = sat_q;
    if (in_valid) begin
      word_d = word_c;
      sat_d  = sat_c;
    end
    sticky_d = (sticky_q && !sticky_clr) || (in_valid && sat_c);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      valid_q  <= 1'b0;
      word_q   <= '0;
      sat_q    <= 1'b0;
      sticky_q <= 1'b0;
    end else begin
      valid_q  <= valid_d;
      sticky_q <= sticky_d;
      if (in_valid) begin
        word_q <= word_d;
        sat_q  <= sat_d;
      end
    end
  end

  assign out_valid  = valid_q;
  assign out_word   = word_q;
  assign out_sat    = sat_q;
  assign sat_sticky = sticky_q;

  assert_bypass_no_flag_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    (in_valid && !sat_en) |=> !out_sat);

  // R5 and R6: a clamped result is always one of the two full-scale words
  assert_clamp_value_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    out_sat |-> (out_word == MAX_POS || out_word == MAX_NEG));

  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    in_valid |=> out_valid);

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    !in_valid |=> (!out_valid && $stable(out_word)));

  assert_sticky_set_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    (out_valid && out_sat) |-> sat_sticky);

  assert_sticky_fall_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    $fell(sat_sticky) |-> $past(sticky_clr));
endmodule

// File: tb/sim_acc_store_sat.sv
module sim_acc_store_sat;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [39:0] acc_in = '0;
  logic        rnd_req = 1'b0;
  logic        rnd_even = 1'b0;
  logic        sat_en = 1'b1;
  logic        sticky_clr = 1'b0;
  logic        out_valid;
  logic [15:0] out_word;
  logic        out_sat;
  logic        sat_sticky;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  acc_store_sat u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .acc_in(acc_in),
    .rnd_req(rnd_req), .rnd_even(rnd_even), .sat_en(sat_en),
    .sticky_clr(sticky_clr), .out_valid(out_valid), .out_word(out_word),
    .out_sat(out_sat), .sat_sticky(sat_sticky)
  );

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic store(input string req, input logic [39:0] acc, input logic rnd,
                       input logic even, input logic sat,
                       input logic [15:0] exp_w, input logic exp_s);
    @(negedge clk);
    in_valid = 1'b1; acc_in = acc; rnd_req = rnd; rnd_even = even; sat_en = sat;
    @(negedge clk);
    in_valid = 1'b0;
    chk(req, "out_valid", {15'd0, out_valid}, 16'd1);
    chk(req, "out_word", out_word, exp_w);
    chk(req, "out_sat", {15'd0, out_sat}, {15'd0, exp_s});
  endtask

  task automatic t_reset;
    chk("R1", "out_valid", {15'd0, out_valid}, 16'd0);
    chk("R1", "out_word", out_word, 16'h0000);
    chk("R1", "out_sat", {15'd0, out_sat}, 16'd0);
    chk("R1", "sat_sticky", {15'd0, sat_sticky}, 16'd0);
  endtask

  task automatic t_examples;
    store("R5", 40'h010FFF1234, 1'b1, 1'b0, 1'b1, 16'h7FFF, 1'b1);
    store("R2", 40'h010FFF1234, 1'b1, 1'b0, 1'b0, 16'h0FFF, 1'b0);
    store("R6", 40'h9B07644410, 1'b0, 1'b0, 1'b1, 16'h8000, 1'b1);
  endtask

  task automatic t_bypass;
    store("R2", 40'h9B07644410, 1'b0, 1'b0, 1'b0, 16'h0764, 1'b0);
    store("R2", 40'h80ABCD0000, 1'b0, 1'b0, 1'b0, 16'hABCD, 1'b0);
    store("R2", 40'h007FFF8000, 1'b1, 1'b0, 1'b0, 16'h8000, 1'b0);
  endtask

  task automatic t_inrange;
    store("R7", 40'h007FFF1234, 1'b0, 1'b0, 1'b1, 16'h7FFF, 1'b0);
    store("R7", 40'hFF80000000, 1'b0, 1'b0, 1'b1, 16'h8000, 1'b0);
    store("R7", 40'hFFFFFFABCD, 1'b0, 1'b0, 1'b1, 16'hFFFF, 1'b0);
  endtask

  task automatic t_boundary;
    store("R5", 40'h0080000000, 1'b0, 1'b0, 1'b1, 16'h7FFF, 1'b1);
    store("R6", 40'hFF7FFFFFFF, 1'b0, 1'b0, 1'b1, 16'h8000, 1'b1);
  endtask

  task automatic t_round;
    store("R3", 40'h0012348000, 1'b1, 1'b0, 1'b1, 16'h1235, 1'b0);
    store("R3", 40'h0012347FFF, 1'b1, 1'b0, 1'b1, 16'h1234, 1'b0);
    store("R3", 40'h001234FFFF, 1'b0, 1'b0, 1'b1, 16'h1234, 1'b0);
  endtask

  task automatic t_even;
    store("R4", 40'h0012348000, 1'b1, 1'b1, 1'b1, 16'h1234, 1'b0);
    store("R4", 40'h0012358000, 1'b1, 1'b1, 1'b1, 16'h1236, 1'b0);
    store("R4", 40'h0012348001, 1'b1, 1'b1, 1'b1, 16'h1235, 1'b0);
    store("R4", 40'h0012358000, 1'b0, 1'b1, 1'b1, 16'h1235, 1'b0);
  endtask

  task automatic t_after_round;
    store("R8", 40'h7FFFFF8000, 1'b1, 1'b0, 1'b1, 16'h8000, 1'b1);
    store("R8", 40'h007FFF8000, 1'b1, 1'b0, 1'b1, 16'h7FFF, 1'b1);
  endtask

  task automatic t_timing;
    store("R9", 40'h0000420000, 1'b0, 1'b0, 1'b1, 16'h0042, 1'b0);
    @(negedge clk);
    chk("R9", "idle out_valid", {15'd0, out_valid}, 16'd0);
    chk("R9", "idle out_word hold", out_word, 16'h0042);
    acc_in = 40'h0000990000;
    @(negedge clk);
    chk("R9", "idle acc ignored", out_word, 16'h0042);
  endtask

  task automatic t_sticky;
    @(negedge clk); sticky_clr = 1'b1;
    @(negedge clk); sticky_clr = 1'b0;
    chk("R10", "cleared", {15'd0, sat_sticky}, 16'd0);
    store("R10", 40'h0000100000, 1'b0, 1'b0, 1'b1, 16'h0010, 1'b0);
    chk("R10", "no clamp keeps clear", {15'd0, sat_sticky}, 16'd0);
    store("R10", 40'h0100000000, 1'b0, 1'b0, 1'b1, 16'h7FFF, 1'b1);
    chk("R10", "set by clamp", {15'd0, sat_sticky}, 16'd1);
    store("R10", 40'h0000100000, 1'b0, 1'b0, 1'b1, 16'h0010, 1'b0);
    chk("R10", "stays set", {15'd0, sat_sticky}, 16'd1);
    @(negedge clk);
    sticky_clr = 1'b1; in_valid = 1'b1; acc_in = 40'hF000000000;
    rnd_req = 1'b0; sat_en = 1'b1;
    @(negedge clk);
    sticky_clr = 1'b0; in_valid = 1'b0;
    chk("R10", "set wins over clear", {15'd0, sat_sticky}, 16'd1);
    chk("R10", "clash word", out_word, 16'h8000);
    @(negedge clk); sticky_clr = 1'b1;
    @(negedge clk); sticky_clr = 1'b0;
    chk("R10", "clear alone", {15'd0, sat_sticky}, 16'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_examples;
    t_bypass;
    t_inrange;
    t_boundary;
    t_round;
    t_even;
    t_after_round;
    t_timing;
    t_sticky;
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL R9 watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule